// File: doc/BRIEF.md
# Serial Port DMA Request and Completion Logic

This block connects the transmit and receive FIFOs of a synchronous serial port to a DMA engine. It watches the occupancy count of each FIFO and raises a single-transfer request and a burst request for each direction. A request is raised only while DMA is enabled for that direction. Receive requests depend on how many items are waiting. Transmit requests depend on how many slots are free.

The block also keeps three sticky raw status bits: receive DMA complete, transmit DMA complete, and end of transmission. Each raw bit is ANDed with its own mask bit, and the masked bits are ORed onto the single interrupt line of the serial port. Software uses a small register write port to set the enables, load the mask, and clear status bits by writing ones.

The transmit-complete bit is protected. A clear request for it is ignored while transmit DMA is still enabled. Software must first turn transmit DMA off and then clear the bit.

Top module: `dreq_dma_link`

## Requirements
- R1: The receive single request `rx_sreq` is high exactly when receive DMA is enabled and `rx_fill` is at least 1.
- R2: The receive burst request `rx_breq` is high exactly when receive DMA is enabled and `rx_fill` is at least 4.
- R3: The transmit single request `tx_sreq` is high exactly when transmit DMA is enabled and the free count (8 − `tx_fill`, with FIFO depth 8) is at least 1.
- R4: The transmit burst request `tx_breq` is high exactly when transmit DMA is enabled and the free count is at least 4.
- R5: A write to address 0 loads receive DMA enable from data bit 0 and transmit DMA enable from data bit 1. The two enables are read back on `rx_dma_en` and `tx_dma_en`. While an enable is 0, both requests of that direction stay low.
- R6: A one-cycle pulse on `dma_tx_done` sets raw status bit 1 (transmit complete) on the next clock edge.
- R7: A write to address 2 with data bit 1 set clears raw bit 1 only if `tx_dma_en` is 0 in that cycle. If `tx_dma_en` is 1, the write leaves the bit set.
- R8: A one-cycle pulse on `dma_rx_done` sets raw status bit 0 (receive complete) on the next clock edge.
- R9: Raw status bit 2 (end of transmission) is set on the clock edge after a cycle in which `tx_fill` is 0 and `shifter_idle` is 1.
- R10: A write to address 2 clears raw bit 0 when data bit 0 is set, and clears raw bit 2 when data bit 2 is set, with no other condition. If a set event and a clear for the same bit occur in the same cycle, the bit ends up set.
- R11: A write to address 1 loads the 3-bit mask. `masked_status` equals raw AND mask, and `irq` is the OR of the masked bits.
- R12: After reset, both enables, the mask and all raw status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_fill | input | 4 | Items held in the receive FIFO |
| tx_fill | input | 4 | Items held in the transmit FIFO |
| shifter_idle | input | 1 | Serializer has sent its final bit |
| dma_rx_done | input | 1 | DMA receive transfer complete pulse |
| dma_tx_done | input | 1 | DMA transmit transfer complete pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 mask, 2 clear |
| reg_wdata | input | 3 | Register write data |
| rx_sreq | output | 1 | Receive single-transfer request |
| rx_breq | output | 1 | Receive burst request |
| tx_sreq | output | 1 | Transmit single-transfer request |
| tx_breq | output | 1 | Transmit burst request |
| rx_dma_en | output | 1 | Receive DMA enable readback |
| tx_dma_en | output | 1 | Transmit DMA enable readback |
| raw_status | output | 3 | Raw status: bit 0 receive done, bit 1 transmit done, bit 2 end of transmission |
| masked_status | output | 3 | Raw status ANDed with the mask |
| irq | output | 1 | Combined interrupt |

## Verification
The request logic is driven with receive fill levels 0, 1, 3, 4 and 8 and transmit fill levels 8, 7, 5, 4 and 0. These levels separate the off-by-one cases at each threshold, and they catch a transmit side that counts items where it should count free slots. The same levels are then applied with each enable cleared alone, which shows that the enables are independent and that they gate both request kinds.

The status tests clear the transmit-complete bit once with transmit DMA enabled and once with it disabled. They also place a set pulse in the same cycle as a clear. This exposes a missing clear guard and a reversed priority between set and clear. A final test walks single mask bits to show that each raw bit reaches `irq` only through its own mask bit.

// File: rtl/dreq_pkg.sv
// Package: shared register addresses and status bit positions for the
// serial-port DMA request block. Assumes a 2-bit register address space.
package dreq_pkg;

    localparam int NSTAT = 3;

    typedef enum logic [1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_MASK  = 2'd1,
        ADDR_CLEAR = 2'd2,
        ADDR_NONE  = 2'd3
    } dreq_addr_e;

    localparam int ST_RXDONE = 0;
    localparam int ST_TXDONE = 1;
    localparam int ST_EOT    = 2;

    localparam int CTL_RXEN = 0;
    localparam int CTL_TXEN = 1;

endpackage

// File: rtl/dreq_req_gen.sv
// Module: request generator for one direction. It derives the single and
// burst requests from a FIFO occupancy count. For transmit (IS_TX=1) the
// count is turned into free slots. Assumes fill never legitimately exceeds
// DEPTH; larger values are treated as full.
module dreq_req_gen #(
    parameter int DEPTH = 8,
    parameter int BURST = 4,
    parameter bit IS_TX = 1'b0,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] fill,
    input  logic          en,
    output logic          sreq,
    output logic          breq
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] BURST_C = CW'(BURST);

    logic [CW-1:0] avail;

    generate
        if (IS_TX) begin : g_tx
            // Purpose: free slot count, saturating at zero when over-full.
            always_comb avail = (fill >= DEPTH_C) ? '0 : DEPTH_C - fill;
        end else begin : g_rx
            // Purpose: occupied item count, capped at the FIFO depth.
            always_comb avail = (fill > DEPTH_C) ? DEPTH_C : fill;
        end
    endgenerate

    // Purpose: threshold compare, gated by the direction enable.
    always_comb begin
        sreq = en && (avail != '0);
        breq = en && (avail >= BURST_C);
    end
endmodule

// File: rtl/dreq_stat_bit.sv
// Module: one sticky raw status bit. A set always wins over a clear in
// the same cycle. A clear is dropped while clr_blk is high.
module dreq_stat_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic clr_blk,
    output logic q
);
    // Purpose: hold, set or conditionally clear the status bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (set)
            q <= 1'b1;
        else if (clr && !clr_blk)
            q <= 1'b0;
    end
endmodule

// File: rtl/dreq_ctrl_regs.sv
// Module: register write decode. It holds the two DMA enables and the
// interrupt mask, and it turns writes to the clear address into one-cycle
// clear pulses. Assumes single-cycle write strobes.
module dreq_ctrl_regs
    import dreq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [1:0]       addr,
    input  logic [NSTAT-1:0] wdata,
    output logic             rx_en,
    output logic             tx_en,
    output logic [NSTAT-1:0] mask,
    output logic [NSTAT-1:0] clr
);
    // Purpose: control register holding the per-direction enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en <= 1'b0;
            tx_en <= 1'b0;
        end else if (wr && addr == ADDR_CTRL) begin
            rx_en <= wdata[CTL_RXEN];
            tx_en <= wdata[CTL_TXEN];
        end
    end

    // Purpose: interrupt mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= '0;
        else if (wr && addr == ADDR_MASK)
            mask <= wdata;
    end

    // Purpose: write-one-to-clear pulses, valid during the write cycle.
    always_comb clr = (wr && addr == ADDR_CLEAR) ? wdata : '0;
endmodule

// File: rtl/dreq_dma_link.sv
// Module: top of the serial-port DMA request and completion logic. It
// raises single and burst requests per direction, keeps the sticky
// completion and end-of-transmission status bits, and masks them onto one
// interrupt. Assumes the done strobes are one-cycle pulses that are
// synchronous to clk.
module dreq_dma_link
    import dreq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int BURST = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    rx_fill,
    input  logic [CW-1:0]    tx_fill,
    input  logic             shifter_idle,
    input  logic             dma_rx_done,
    input  logic             dma_tx_done,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [NSTAT-1:0] reg_wdata,
    output logic             rx_sreq,
    output logic             rx_breq,
    output logic             tx_sreq,
    output logic             tx_breq,
    output logic             rx_dma_en,
    output logic             tx_dma_en,
    output logic [NSTAT-1:0] raw_status,
    output logic [NSTAT-1:0] masked_status,
    output logic             irq
);
    logic [NSTAT-1:0] mask;
    logic [NSTAT-1:0] clr;
    logic [NSTAT-1:0] set_ev;
    logic [NSTAT-1:0] blk;

    dreq_ctrl_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rx_en (rx_dma_en),
        .tx_en (tx_dma_en),
        .mask  (mask),
        .clr   (clr)
    );

    dreq_req_gen #(.DEPTH(DEPTH), .BURST(BURST), .IS_TX(1'b0), .CW(CW)) u_rx_req (
        .fill (rx_fill),
        .en   (rx_dma_en),
        .sreq (rx_sreq),
        .breq (rx_breq)
    );

    dreq_req_gen #(.DEPTH(DEPTH), .BURST(BURST), .IS_TX(1'b1), .CW(CW)) u_tx_req (
        .fill (tx_fill),
        .en   (tx_dma_en),
        .sreq (tx_sreq),
        .breq (tx_breq)
    );

    // Purpose: map set events and clear guards onto the status bit positions.
    always_comb begin
        set_ev            = '0;
        blk               = '0;
        set_ev[ST_RXDONE] = dma_rx_done;
        set_ev[ST_TXDONE] = dma_tx_done;
        set_ev[ST_EOT]    = (tx_fill == '0) && shifter_idle;
        blk[ST_TXDONE]    = tx_dma_en;
    end

    generate
        for (genvar i = 0; i < NSTAT; i++) begin : g_stat
            dreq_stat_bit u_bit (
                .clk     (clk),
                .rst_n   (rst_n),
                .set     (set_ev[i]),
                .clr     (clr[i]),
                .clr_blk (blk[i]),
                .q       (raw_status[i])
            );
        end
    endgenerate

    // Purpose: masked status and the combined interrupt line.
    always_comb begin
        masked_status = raw_status & mask;
        irq           = |masked_status;
    end
endmodule

// File: rtl/dreq_dma_link_chk.sv
// Module: assertion checker for dreq_dma_link. It is bound to every
// instance of the top module.
module dreq_dma_link_chk #(
    parameter int NS = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_sreq,
    input logic          rx_breq,
    input logic          tx_sreq,
    input logic          tx_breq,
    input logic          rx_dma_en,
    input logic          tx_dma_en,
    input logic          dma_rx_done,
    input logic          dma_tx_done,
    input logic [NS-1:0] raw_status,
    input logic [NS-1:0] masked_status,
    input logic          irq
);
    a_r2_rx_burst_implies_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_breq |-> rx_sreq);
    a_r4_tx_burst_implies_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_breq |-> tx_sreq);
    a_r5_rx_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_dma_en |-> (!rx_sreq && !rx_breq));
    a_r5_tx_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_dma_en |-> (!tx_sreq && !tx_breq));
    a_r6_tx_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        dma_tx_done |=> raw_status[1]);
    a_r7_tx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_dma_en && raw_status[1]) |=> raw_status[1]);
    a_r8_rx_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rx_done |=> raw_status[0]);
    a_r11_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (masked_status != '0));
    a_r11_masked_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_status & ~raw_status) == '0);
endmodule

bind dreq_dma_link dreq_dma_link_chk #(.NS(dreq_pkg::NSTAT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_sreq       (rx_sreq),
    .rx_breq       (rx_breq),
    .tx_sreq       (tx_sreq),
    .tx_breq       (tx_breq),
    .rx_dma_en     (rx_dma_en),
    .tx_dma_en     (tx_dma_en),
    .dma_rx_done   (dma_rx_done),
    .dma_tx_done   (dma_tx_done),
    .raw_status    (raw_status),
    .masked_status (masked_status),
    .irq           (irq)
);

// File: tb/sim_dreq_dma_link.sv
module sim_dreq_dma_link;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] rx_fill = 4'd0;
    logic [3:0] tx_fill = 4'd8;
    logic       shifter_idle = 1'b0;
    logic       dma_rx_done = 1'b0;
    logic       dma_tx_done = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [2:0] reg_wdata = 3'd0;
    logic       rx_sreq, rx_breq, tx_sreq, tx_breq, rx_dma_en, tx_dma_en, irq;
    logic [2:0] raw_status, masked_status;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    dreq_dma_link u0 (
        .clk(clk), .rst_n(rst_n), .rx_fill(rx_fill), .tx_fill(tx_fill),
        .shifter_idle(shifter_idle), .dma_rx_done(dma_rx_done),
        .dma_tx_done(dma_tx_done), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rx_sreq(rx_sreq), .rx_breq(rx_breq),
        .tx_sreq(tx_sreq), .tx_breq(tx_breq), .rx_dma_en(rx_dma_en),
        .tx_dma_en(tx_dma_en), .raw_status(raw_status),
        .masked_status(masked_status), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Write one register; the result is visible at the returning negedge.
    task automatic wr(input logic [1:0] a, input logic [2:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 3'd0;
    endtask

    task automatic t_reset();
        chk("R12 enables", {6'd0, tx_dma_en, rx_dma_en}, 8'd0);
        chk("R12 raw", {5'd0, raw_status}, 8'd0);
        chk("R12 irq", {7'd0, irq}, 8'd0);
    endtask

    task automatic t_rx_levels();
        logic [3:0] lv [5] = '{4'd0, 4'd1, 4'd3, 4'd4, 4'd8};
        wr(2'd0, 3'b011);
        chk("R5 readback", {6'd0, tx_dma_en, rx_dma_en}, 8'd3);
        foreach (lv[i]) begin
            rx_fill = lv[i];
            #1;
            chk("R1 rx single", {7'd0, rx_sreq}, {7'd0, lv[i] >= 4'd1});
            chk("R2 rx burst", {7'd0, rx_breq}, {7'd0, lv[i] >= 4'd4});
        end
    endtask

    task automatic t_tx_levels();
        logic [3:0] lv [5] = '{4'd8, 4'd7, 4'd5, 4'd4, 4'd0};
        foreach (lv[i]) begin
            tx_fill = lv[i];
            #1;
            chk("R3 tx single", {7'd0, tx_sreq}, {7'd0, (4'd8 - lv[i]) >= 4'd1});
            chk("R4 tx burst", {7'd0, tx_breq}, {7'd0, (4'd8 - lv[i]) >= 4'd4});
        end
        tx_fill = 4'd8;
    endtask

    task automatic t_enable_gate();
        rx_fill = 4'd8; tx_fill = 4'd0;
        wr(2'd0, 3'b010);
        #1;
        chk("R5 rx off single", {7'd0, rx_sreq}, 8'd0);
        chk("R5 rx off burst", {7'd0, rx_breq}, 8'd0);
        chk("R5 tx still on", {6'd0, tx_sreq, tx_breq}, 8'd3);
        wr(2'd0, 3'b001);
        #1;
        chk("R5 tx off", {6'd0, tx_sreq, tx_breq}, 8'd0);
        chk("R5 rx on", {6'd0, rx_sreq, rx_breq}, 8'd3);
        tx_fill = 4'd8; rx_fill = 4'd0;
    endtask

    task automatic t_tx_done();
        wr(2'd0, 3'b010);
        @(negedge clk); dma_tx_done = 1'b1;
        @(negedge clk); dma_tx_done = 1'b0;
        chk("R6 tx done set", {7'd0, raw_status[1]}, 8'd1);
        wr(2'd2, 3'b010);
        chk("R7 clear blocked", {7'd0, raw_status[1]}, 8'd1);
        wr(2'd0, 3'b000);
        wr(2'd2, 3'b010);
        chk("R7 clear allowed", {7'd0, raw_status[1]}, 8'd0);
    endtask

    task automatic t_rx_done();
        @(negedge clk); dma_rx_done = 1'b1;
        @(negedge clk); dma_rx_done = 1'b0;
        chk("R8 rx done set", {7'd0, raw_status[0]}, 8'd1);
        wr(2'd2, 3'b001);
        chk("R10 rx clear", {7'd0, raw_status[0]}, 8'd0);
        // Set and clear in the same cycle: set must win.
        @(negedge clk);
        dma_rx_done = 1'b1; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 3'b001;
        @(negedge clk);
        dma_rx_done = 1'b0; reg_wr = 1'b0; reg_wdata = 3'd0;
        chk("R10 set wins", {7'd0, raw_status[0]}, 8'd1);
    endtask

    task automatic t_eot();
        tx_fill = 4'd1; shifter_idle = 1'b1;
        @(negedge clk);
        chk("R9 not empty", {7'd0, raw_status[2]}, 8'd0);
        tx_fill = 4'd0;
        @(negedge clk);
        chk("R9 eot set", {7'd0, raw_status[2]}, 8'd1);
        shifter_idle = 1'b0; tx_fill = 4'd8;
        wr(2'd2, 3'b100);
        chk("R10 eot clear", {7'd0, raw_status[2]}, 8'd0);
    endtask

    task automatic t_mask();
        // raw bit 0 is set from t_rx_done
        chk("R11 mask zero irq", {7'd0, irq}, 8'd0);
        wr(2'd1, 3'b010);
        chk("R11 other mask", {4'd0, irq, masked_status}, 8'd0);
        wr(2'd1, 3'b001);
        chk("R11 own mask", {4'd0, irq, masked_status}, 8'h09);
        wr(2'd2, 3'b001);
        chk("R11 irq drops", {7'd0, irq}, 8'd0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_rx_levels();
                t_tx_levels();
                t_enable_gate();
                t_tx_done();
                t_rx_done();
                t_eot();
                t_mask();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule